// File: doc/BRIEF.md
# CIC Interpolation Filter

A fixed-ratio cascaded integrator-comb interpolator that turns a slow stream of signed samples into a full clock-rate stream. A phase counter opens one input slot every `RATE` clocks (default 100, so a 125 MHz clock gives a 1.25 MHz input rate). In that slot the block raises `in_ready_o`. If `in_valid_i` is also high, it takes `in_data_i`. If not, the slot carries a zero sample. The sample passes through `STAGES` comb sections (default 3, differential delay 1) that run only in input slots. The comb result is held for one clock and followed by `RATE-1` zeros. It then enters `STAGES` integrators that run on every clock.

All internal arithmetic is `IN_W+20` bits wide and wraps in two's complement. The output is a fixed slice of the last integrator: a right shift by `SHIFT` bits, then truncation to `OUT_W` bits. `OUT_W` and `SHIFT` are set so the next stage sees the scale it expects. One example is a 25-bit output from a 24-bit input, which doubles the amplitude relative to a 24-bit slice. A new output is available on every clock.

Top module: `cic_interp`

## Requirements
- R1: While `rst_ni` is low, `out_o` is 0 and `in_ready_o` is 1. After release, the first rising edge is an input slot.
- R2: `in_ready_o` is high for exactly one clock in every `RATE` clocks, and low for the `RATE-1` clocks between those slots.
- R3: A sample is taken only on an edge where `in_valid_i` and `in_ready_o` are both high. `in_data_i` and `in_valid_i` have no effect on any later output while `in_ready_o` is low.
- R4: A slot with `in_valid_i` low feeds a zero sample into the combs. Between slots, the integrators receive zero.
- R5: `out_o` equals bits `[SHIFT+OUT_W-1:SHIFT]` of the last integrator. That integrator is the `STAGES`-fold running sum of the zero-stuffed `STAGES`-fold first difference of the slot samples, computed modulo 2^(IN_W+20).
- R6: With a constant accepted input x in every slot, the settled output is floor(x·RATE^(STAGES-1) / 2^SHIFT).
- R7: A single accepted sample x reaches the last integrator 3 edges after the accepting edge. Before the next slot, the value there after edge 3+j is x·(j+1)(j+2)/2 (default three stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input sample present |
| in_data_i | input | IN_W | Signed input sample |
| in_ready_o | output | 1 | Input slot open this clock |
| out_o | output | OUT_W | Signed output sample, one per clock |

## Verification
The bench uses the default build: a 14-bit input, 3 stages, a ratio of 100, a shift of 13 and a 15-bit output. This places the settled DC gain of 10000/8192 and the quadratic impulse ramp within a few hundred clocks. With a 34-bit internal width, full-scale random input never needs the wrap path except through the model, so every output clock is compared bit-exactly against an independent behavioural model. Directed phases cover off-slot valid pulses, empty slots with junk data, a single impulse, and DC at both signs.

// File: rtl/cic_pkg.sv
package cic_pkg;
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cic_phase.sv
module cic_phase #(
  parameter int unsigned RATE = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic slot_o
);
  localparam int unsigned CW = cic_pkg::cnt_width(RATE);
  localparam logic [CW-1:0] LAST = CW'(RATE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign slot_o = (cnt_q == '0);

  assert_phase_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> slot_o);
endmodule

// File: rtl/cic_comb_bank.sv
module cic_comb_bank #(
  parameter int unsigned W      = 34,
  parameter int unsigned STAGES = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] y_o
);
  logic signed [W-1:0] sig [STAGES+1];
  logic signed [W-1:0] dly_q [STAGES];

  assign sig[0] = x_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_comb
    assign sig[k+1] = sig[k] - dly_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q[k] <= '0;
      else if (load_i) dly_q[k] <= sig[k];
    end

    // combs advance only in input slots
    assert_comb_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(dly_q[k]));
  end

  assign y_o = sig[STAGES];
endmodule

// File: rtl/cic_integ_bank.sv
module cic_integ_bank #(
  parameter int unsigned W      = 34,
  parameter int unsigned STAGES = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] d_i,
  output logic signed [W-1:0] acc_o
);
  logic signed [W-1:0] acc_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_int
    logic signed [W-1:0] feed;
    if (k == 0) begin : g_first
      assign feed = d_i;
    end else begin : g_next
      assign feed = acc_q[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q[k] <= '0;
      else acc_q[k] <= acc_q[k] + feed;
    end
  end

  assign acc_o = acc_q[STAGES-1];
endmodule

// File: rtl/cic_interp.sv
module cic_interp #(
  parameter int unsigned IN_W   = 14,
  parameter int unsigned OUT_W  = 15,
  parameter int unsigned SHIFT  = 13,
  parameter int unsigned STAGES = 3,
  parameter int unsigned RATE   = 100
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  in_data_i,
  output logic                    in_ready_o,
  output logic signed [OUT_W-1:0] out_o
);
  localparam int unsigned INT_W = IN_W + 20;

  logic                     slot;
  logic signed [INT_W-1:0]  comb_in, comb_out, up_q, acc;

  cic_phase #(.RATE(RATE)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_o(slot)
  );

  // empty slot feeds zero
  assign comb_in = (slot && in_valid_i) ? INT_W'(in_data_i) : '0;

  cic_comb_bank #(.W(INT_W), .STAGES(STAGES)) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(slot), .x_i(comb_in), .y_o(comb_out)
  );

  // zero-stuffing upsampler
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) up_q <= '0;
    else up_q <= slot ? comb_out : '0;
  end

  cic_integ_bank #(.W(INT_W), .STAGES(STAGES)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(up_q), .acc_o(acc)
  );

  function automatic logic [OUT_W-1:0] take_slice(input logic [INT_W-1:0] v);
    logic [INT_W-1:0] s;
    s = v >> SHIFT;
    return s[OUT_W-1:0];
  endfunction

  assign out_o      = take_slice(acc);
  assign in_ready_o = slot;

  assert_ready_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o);

  assert_stuff_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> (up_q == '0));
endmodule

// File: tb/cic_interp_test.sv
module cic_interp_test;
  localparam int IN_W = 14, OUT_W = 15, SHIFT = 13, STAGES = 3, RATE = 100;
  localparam int INT_W = IN_W + 20;

  logic clk = 1'b0, rst_ni = 1'b0, in_valid = 1'b0;
  logic signed [IN_W-1:0]  in_data = '0;
  logic                    in_ready;
  logic signed [OUT_W-1:0] out;

  always #4ns clk = ~clk;

  cic_interp #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT), .STAGES(STAGES), .RATE(RATE)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_o(out)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R5";

  longint m_d [STAGES];
  longint m_i [STAGES];
  longint m_up;
  int     m_ph;

  function automatic longint sx(input longint v, input int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic longint exp_out();
    return sx(m_i[STAGES-1] >>> SHIFT, OUT_W);
  endfunction

  task automatic chk(input bit ok, input string t, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", t, act, expv);
    end
  endtask

  // advance one clock, update model with applied inputs, compare
  task automatic cyc();
    longint c [STAGES+1];
    bit slot;
    @(negedge clk);
    slot = (m_ph == 0);
    c[0] = (slot && in_valid) ? longint'(in_data) : 0;
    for (int k = 0; k < STAGES; k++) c[k+1] = sx(c[k] - m_d[k], INT_W);
    for (int k = STAGES-1; k > 0; k--) m_i[k] = sx(m_i[k] + m_i[k-1], INT_W);
    m_i[0] = sx(m_i[0] + m_up, INT_W);
    m_up = slot ? c[STAGES] : 0;
    if (slot) for (int k = 0; k < STAGES; k++) m_d[k] = c[k];
    m_ph = (m_ph + 1) % RATE;
    chk(longint'(out) == exp_out(), tag, longint'(out), exp_out());
    chk(in_ready == (m_ph == 0), "R2", longint'(in_ready), longint'(m_ph == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint imp;
    for (int k = 0; k < STAGES; k++) begin m_d[k] = 0; m_i[k] = 0; end
    m_up = 0; m_ph = 0;
    repeat (3) @(negedge clk);
    chk(out == '0, "R1", longint'(out), 0);
    chk(in_ready == 1'b1, "R1", longint'(in_ready), 1);
    rst_ni = 1'b1;

    // impulse in the first slot after reset
    imp = 8191;
    tag = "R7";
    in_valid = 1'b1; in_data = 14'sd8191;
    for (int n = 1; n <= 100; n++) begin
      cyc();
      in_valid = 1'b0; in_data = 14'sd1234;
      if (n <= 3) chk(out == '0, "R7", longint'(out), 0);
      if (n >= 4 && n <= 100) begin
        longint j, ref_v;
        j = n - 4;
        ref_v = (imp * (j + 1) * (j + 2) / 2) >>> SHIFT;
        chk(longint'(out) == ref_v, "R7", longint'(out), ref_v);
      end
    end

    // empty slots with junk data
    tag = "R4";
    for (int n = 0; n < 400; n++) begin
      in_valid = 1'b0; in_data = IN_W'($urandom);
      cyc();
    end
    chk(out == '0, "R4", longint'(out), 0);

    // valid only while ready is low
    tag = "R3";
    for (int n = 0; n < 300; n++) begin
      in_valid = (m_ph != 0); in_data = IN_W'($urandom);
      cyc();
    end
    chk(out == '0, "R3", longint'(out), 0);

    // DC at both signs
    tag = "R6";
    for (int s = 0; s < 2; s++) begin
      longint x, ref_v;
      x = (s == 0) ? 5000 : -5000;
      in_valid = 1'b1; in_data = IN_W'(x);
      for (int n = 0; n < 600; n++) cyc();
      ref_v = (x * 10000) >>> SHIFT;
      chk(longint'(out) == ref_v, "R6", longint'(out), ref_v);
    end

    // random, with full-scale corner samples
    tag = "R5";
    void'($urandom(32'd7));
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      in_valid = (r < 8);
      if (r == 0)      in_data = 14'sh1FFF;
      else if (r == 1) in_data = 14'sh2000;
      else             in_data = IN_W'($urandom);
      cyc();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule